// File: doc/BRIEF.md
# Register Rename Table with Reorder Buffer

This block is the out-of-order core of a small ALU-only machine. Each cycle it can take one new instruction (an opcode, two source register numbers and a destination register number), rename it against a per-register mapping table, and place it at the tail of a circular reorder buffer. Entries whose two operands are both available wait to be picked for execution. Among those, the oldest one is driven to an external combinational ALU, and the ALU's answer is written back into that entry in the same cycle. The same answer is broadcast to every operand that is waiting on that entry.

Finished entries leave the buffer strictly from the head, in program order. Each one writes its value into the architectural register held next to the mapping table. An exception raised while the buffer holds instructions discards every in-flight entry and every mapping. The committed register values are kept. An external busy signal can hold off execution, and this is what lets the buffer fill up and stall dispatch.

Top module: `ooo_rename_rob`

## Requirements
- R1: After reset the buffer is empty, `disp_ready` is 1, `exe_valid` and `ret_valid` are 0, and every architectural register holds 0.
- R2: Dispatch is accepted when `disp_valid` is 1 and fewer than DEPTH entries are occupied. With DEPTH entries occupied, `disp_ready` is 0 and the offered instruction is dropped. Occupancy comes from head and tail pointers that each carry one wrap bit above the index.
- R3: At dispatch, a source whose register has no mapping takes the committed register value and is ready. A source that maps to an entry that has already executed takes that entry's result and is ready. Any other mapped source waits on the tag, which is the buffer index of its producer.
- R4: When `alu_busy` is 0, the oldest entry (counted from the head) that is occupied, not yet executed and has both operands ready appears on `exe_valid`/`exe_tag`/`exe_op`/`exe_a`/`exe_b`. `exe_tag` is its buffer index. `exe_result` is stored as that entry's result at the clock edge. When `alu_busy` is 1, nothing executes.
- R5: An executed result is broadcast. Every waiting operand whose tag equals the executing entry's index captures the result and becomes ready.
- R6: If a dispatched source maps to the entry that executes in the same cycle, the source takes `exe_result` directly and is ready.
- R7: Only the head entry retires, and only after it has executed. `ret_valid` then shows its destination register on `ret_reg` and its result on `ret_data`, and the head advances by one. At most one entry retires per cycle.
- R8: A retiring result is written to its architectural register. That register's mapping is removed only if it still points at the retiring index, so a younger mapping to the same register stays in force.
- R9: `exc_in` while at least one entry is occupied empties the buffer (tail set to head), removes every mapping, and suppresses execution, retirement and dispatch in that cycle. Committed register values are kept. `exc_in` with an empty buffer has no effect.
- R10: Every mapped register points at an occupied entry that lies between head (inclusive) and tail (exclusive), and that entry names the register as its destination.
- R11: Every occupied entry's destination register is mapped, and the mapping points at that entry or at a younger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A new instruction is offered |
| disp_op | input | OP_W | Opcode of the offered instruction |
| disp_src1 | input | log2(REGS) | First source register |
| disp_src2 | input | log2(REGS) | Second source register |
| disp_dst | input | log2(REGS) | Destination register |
| disp_ready | output | 1 | Buffer not full; an offered instruction is taken |
| alu_busy | input | 1 | Holds off execution this cycle |
| exe_valid | output | 1 | An entry is executing this cycle |
| exe_tag | output | log2(DEPTH) | Buffer index of the executing entry |
| exe_op | output | OP_W | Opcode of the executing entry |
| exe_a | output | DATA_W | First operand value |
| exe_b | output | DATA_W | Second operand value |
| exe_result | input | DATA_W | ALU answer for the executing entry |
| exc_in | input | 1 | Exception at the head; flushes the machine |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_reg | output | log2(REGS) | Register written by the retiring entry |
| ret_data | output | DATA_W | Value written by the retiring entry |

## Verification
The assertions check the consistency between the mapping table and the buffer on every cycle (R10, R11): every mapping points into the live window at an entry with the matching destination, and every live entry is covered by a mapping. They also check on every cycle that occupancy never passes DEPTH, that an executing entry really is ready and unexecuted, that a retirement advances the head by exactly one, and that a flush leaves no entries and no mappings. Correct values can only be shown by the bench's reference model comparing the execute and retire ports cycle by cycle. This covers operand sourcing from committed registers, wakeup, same-cycle bypass, a younger mapping surviving an older retirement, and committed state surviving a flush. Its scenarios include a full-buffer stall held by `alu_busy` and a long random stream with exceptions.

// File: rtl/ooo_pkg.sv
package ooo_pkg;

  // Distance from a ring position 'from' forward to 'to' on a ring of 'depth'.
  function automatic int ring_dist(input int from, input int to, input int depth);
    return (to - from + depth) % depth;
  endfunction

endpackage

// File: rtl/ooo_rename_map.sv
module ooo_rename_map #(
  parameter int DATA_W = 16,
  parameter int REGS   = 8,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [$clog2(REGS)-1:0]  rd1_reg,
  input  logic [$clog2(REGS)-1:0]  rd2_reg,
  output logic                     rd1_mapped,
  output logic [$clog2(DEPTH)-1:0] rd1_tag,
  output logic [DATA_W-1:0]        rd1_val,
  output logic                     rd2_mapped,
  output logic [$clog2(DEPTH)-1:0] rd2_tag,
  output logic [DATA_W-1:0]        rd2_val,
  input  logic                     map_en,
  input  logic [$clog2(REGS)-1:0]  map_reg,
  input  logic [$clog2(DEPTH)-1:0] map_tag,
  input  logic                     ret_en,
  input  logic [$clog2(REGS)-1:0]  ret_reg,
  input  logic [$clog2(DEPTH)-1:0] ret_tag,
  input  logic [DATA_W-1:0]        ret_val,
  output logic                     map_valid [REGS],
  output logic [$clog2(DEPTH)-1:0] map_tag_o [REGS]
);
  localparam int REG_W = $clog2(REGS);

  logic [DATA_W-1:0] arch [REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < REGS; r++) begin
        map_valid[r] <= 1'b0;
        map_tag_o[r] <= '0;
        arch[r]      <= '0;
      end
    end else begin
      for (int r = 0; r < REGS; r++) begin
        if (flush) begin
          map_valid[r] <= 1'b0;
        end else begin
          if (ret_en && ret_reg == REG_W'(r)) begin
            arch[r] <= ret_val;
            if (map_tag_o[r] == ret_tag) map_valid[r] <= 1'b0;  // older mapping only
          end
          if (map_en && map_reg == REG_W'(r)) begin
            map_valid[r] <= 1'b1;
            map_tag_o[r] <= map_tag;
          end
        end
      end
    end
  end

  assign rd1_mapped = map_valid[rd1_reg];
  assign rd1_tag    = map_tag_o[rd1_reg];
  assign rd1_val    = arch[rd1_reg];
  assign rd2_mapped = map_valid[rd2_reg];
  assign rd2_tag    = map_tag_o[rd2_reg];
  assign rd2_val    = arch[rd2_reg];

endmodule

// File: rtl/ooo_issue_pick.sv
module ooo_issue_pick #(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0]         ready,
  input  logic [$clog2(DEPTH)-1:0] base,
  output logic                     pick_v,
  output logic [$clog2(DEPTH)-1:0] pick_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  // Scan youngest to oldest so the oldest ready entry is the last writer.
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = base;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (ready[IDX_W'((int'(base) + k) % DEPTH)]) begin
        pick_v   = 1'b1;
        pick_idx = IDX_W'((int'(base) + k) % DEPTH);
      end
    end
  end

endmodule

// File: rtl/ooo_rename_rob.sv
module ooo_rename_rob #(
  parameter int DATA_W = 16,
  parameter int REGS   = 8,
  parameter int DEPTH  = 4,
  parameter int OP_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic [OP_W-1:0]          disp_op,
  input  logic [$clog2(REGS)-1:0]  disp_src1,
  input  logic [$clog2(REGS)-1:0]  disp_src2,
  input  logic [$clog2(REGS)-1:0]  disp_dst,
  output logic                     disp_ready,
  input  logic                     alu_busy,
  output logic                     exe_valid,
  output logic [$clog2(DEPTH)-1:0] exe_tag,
  output logic [OP_W-1:0]          exe_op,
  output logic [DATA_W-1:0]        exe_a,
  output logic [DATA_W-1:0]        exe_b,
  input  logic [DATA_W-1:0]        exe_result,
  input  logic                     exc_in,
  output logic                     ret_valid,
  output logic [$clog2(REGS)-1:0]  ret_reg,
  output logic [DATA_W-1:0]        ret_data
);
  import ooo_pkg::*;

  localparam int REG_W = $clog2(REGS);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  // Buffer entries
  logic              e_valid [DEPTH];
  logic              e_done  [DEPTH];
  logic [OP_W-1:0]   e_op    [DEPTH];
  logic [REG_W-1:0]  e_dst   [DEPTH];
  logic [DATA_W-1:0] e_res   [DEPTH];
  logic              s1_rdy  [DEPTH];
  logic [DATA_W-1:0] s1_val  [DEPTH];
  logic [IDX_W-1:0]  s1_tag  [DEPTH];
  logic              s2_rdy  [DEPTH];
  logic [DATA_W-1:0] s2_val  [DEPTH];
  logic [IDX_W-1:0]  s2_tag  [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, occ;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full, empty;

  // Named internal events
  logic             flush, disp_fire, exe_fire, ret_fire;
  logic [DEPTH-1:0] ready_vec;
  logic             pick_v;
  logic [IDX_W-1:0] pick_idx;

  // Rename lookups
  logic              m1_v, m2_v;
  logic [IDX_W-1:0]  m1_tag, m2_tag;
  logic [DATA_W-1:0] m1_val, m2_val;
  logic              map_valid [REGS];
  logic [IDX_W-1:0]  map_tag   [REGS];
  logic [REGS-1:0]   map_vec;
  logic [DATA_W:0]   op1, op2;

  // {ready, value} for a dispatched source
  function automatic logic [DATA_W:0] resolve(
    input logic mapped, input logic prod_done, input logic [DATA_W-1:0] prod_res,
    input logic bcast_hit, input logic [DATA_W-1:0] bcast_val,
    input logic [DATA_W-1:0] committed);
    if (!mapped)   return {1'b1, committed};
    if (prod_done) return {1'b1, prod_res};
    if (bcast_hit) return {1'b1, bcast_val};
    return {1'b0, committed};
  endfunction

  assign head_idx   = head_q[IDX_W-1:0];
  assign tail_idx   = tail_q[IDX_W-1:0];
  assign occ        = tail_q - head_q;
  assign full       = (occ == PTR_W'(DEPTH));
  assign empty      = (occ == '0);
  assign flush      = exc_in && !empty;
  assign disp_ready = !full;
  assign disp_fire  = disp_valid && !full && !flush;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
      assign ready_vec[i] = e_valid[i] && !e_done[i] && s1_rdy[i] && s2_rdy[i];
    end
    for (genvar r = 0; r < REGS; r++) begin : g_mv
      assign map_vec[r] = map_valid[r];
    end
  endgenerate

  ooo_issue_pick #(.DEPTH(DEPTH)) i_pick (
    .ready(ready_vec), .base(head_idx), .pick_v(pick_v), .pick_idx(pick_idx)
  );

  assign exe_fire  = pick_v && !flush && !alu_busy;
  assign exe_valid = exe_fire;
  assign exe_tag   = pick_idx;
  assign exe_op    = e_op[pick_idx];
  assign exe_a     = s1_val[pick_idx];
  assign exe_b     = s2_val[pick_idx];

  assign ret_fire  = e_valid[head_idx] && e_done[head_idx] && !flush;
  assign ret_valid = ret_fire;
  assign ret_reg   = e_dst[head_idx];
  assign ret_data  = e_res[head_idx];

  ooo_rename_map #(.DATA_W(DATA_W), .REGS(REGS), .DEPTH(DEPTH)) i_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd1_reg(disp_src1), .rd2_reg(disp_src2),
    .rd1_mapped(m1_v), .rd1_tag(m1_tag), .rd1_val(m1_val),
    .rd2_mapped(m2_v), .rd2_tag(m2_tag), .rd2_val(m2_val),
    .map_en(disp_fire), .map_reg(disp_dst), .map_tag(tail_idx),
    .ret_en(ret_fire), .ret_reg(e_dst[head_idx]), .ret_tag(head_idx),
    .ret_val(e_res[head_idx]),
    .map_valid(map_valid), .map_tag_o(map_tag)
  );

  assign op1 = resolve(m1_v, e_done[m1_tag], e_res[m1_tag],
                       exe_fire && pick_idx == m1_tag, exe_result, m1_val);
  assign op2 = resolve(m2_v, e_done[m2_tag], e_res[m2_tag],
                       exe_fire && pick_idx == m2_tag, exe_result, m2_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_valid[i] <= 1'b0; e_done[i] <= 1'b0; e_op[i] <= '0; e_dst[i] <= '0;
        e_res[i] <= '0; s1_rdy[i] <= 1'b0; s1_val[i] <= '0; s1_tag[i] <= '0;
        s2_rdy[i] <= 1'b0; s2_val[i] <= '0; s2_tag[i] <= '0;
      end
    end else if (flush) begin
      tail_q <= head_q;
      for (int i = 0; i < DEPTH; i++) e_valid[i] <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (exe_fire && pick_idx == IDX_W'(i)) begin
          e_done[i] <= 1'b1;
          e_res[i]  <= exe_result;
        end
        if (exe_fire && e_valid[i] && !s1_rdy[i] && s1_tag[i] == pick_idx) begin
          s1_rdy[i] <= 1'b1;
          s1_val[i] <= exe_result;
        end
        if (exe_fire && e_valid[i] && !s2_rdy[i] && s2_tag[i] == pick_idx) begin
          s2_rdy[i] <= 1'b1;
          s2_val[i] <= exe_result;
        end
      end
      if (ret_fire) begin
        e_valid[head_idx] <= 1'b0;
        head_q            <= head_q + 1'b1;
      end
      if (disp_fire) begin
        e_valid[tail_idx] <= 1'b1;
        e_done[tail_idx]  <= 1'b0;
        e_op[tail_idx]    <= disp_op;
        e_dst[tail_idx]   <= disp_dst;
        s1_rdy[tail_idx]  <= op1[DATA_W];
        s1_val[tail_idx]  <= op1[DATA_W-1:0];
        s1_tag[tail_idx]  <= m1_tag;
        s2_rdy[tail_idx]  <= op2[DATA_W];
        s2_val[tail_idx]  <= op2[DATA_W-1:0];
        s2_tag[tail_idx]  <= m2_tag;
        tail_q            <= tail_q + 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH); // R2

  AST_EXEC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |-> (e_valid[exe_tag] && !e_done[exe_tag] && s1_rdy[exe_tag] && s2_rdy[exe_tag])); // R4

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (head_q == PTR_W'($past(head_q) + 1'b1))); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((head_q == tail_q) && ($countones(map_vec) == 0))); // R9

  generate
    for (genvar r = 0; r < REGS; r++) begin : g_chk_map
      AST_MAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid[r] |-> ((ring_dist(int'(head_idx), int'(map_tag[r]), DEPTH) < int'(occ))
                          && e_valid[map_tag[r]] && e_dst[map_tag[r]] == REG_W'(r))); // R10
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_chk_ent
      AST_ENTRY_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        e_valid[i] |-> (map_valid[e_dst[i]]
          && ring_dist(int'(head_idx), int'(map_tag[e_dst[i]]), DEPTH)
             >= ring_dist(int'(head_idx), i, DEPTH))); // R11
    end
  endgenerate

endmodule

// File: tb/test_ooo_rename_rob.sv
module test_ooo_rename_rob;
  localparam int DATA_W = 16;
  localparam int REGS   = 8;
  localparam int DEPTH  = 4;
  localparam int OP_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [OP_W-1:0] disp_op = '0;
  logic [2:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic disp_ready;
  logic alu_busy = 1'b0;
  logic exe_valid;
  logic [1:0] exe_tag;
  logic [OP_W-1:0] exe_op;
  logic [DATA_W-1:0] exe_a, exe_b;
  logic [DATA_W-1:0] exe_result = '0;
  logic exc_in = 1'b0;
  logic ret_valid;
  logic [2:0] ret_reg;
  logic [DATA_W-1:0] ret_data;

  always #2 clk = ~clk;

  ooo_rename_rob #(.DATA_W(DATA_W), .REGS(REGS), .DEPTH(DEPTH), .OP_W(OP_W)) i_ooo_rename_rob (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_src1(disp_src1), .disp_src2(disp_src2), .disp_dst(disp_dst),
    .disp_ready(disp_ready), .alu_busy(alu_busy), .exe_valid(exe_valid),
    .exe_tag(exe_tag), .exe_op(exe_op), .exe_a(exe_a), .exe_b(exe_b),
    .exe_result(exe_result), .exc_in(exc_in), .ret_valid(ret_valid),
    .ret_reg(ret_reg), .ret_data(ret_data));

  // ---------- reference model: program-ordered list of in-flight instructions ----------
  typedef struct {
    int seq; int op; int dst;
    bit r1; int v1; int t1;
    bit r2; int v2; int t2;
    bit done; int res;
  } inst_t;

  inst_t flight[$];
  int owner[REGS];   // producing sequence number, -1 when none
  int regval[REGS];
  int head_seq, tail_seq;
  int checks, errors;
  bit finished;

  function automatic int alu(int op, int a, int b);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a ^ b;
      3: r = a + 257;
      default: r = a + 3 * b + op + 1;
    endcase
    return r & 16'hFFFF;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Operand source: {ready, value-or-producer}
  task automatic source(int s, output bit rdy, output int v, output int t);
    rdy = 1'b1; v = regval[s]; t = -1;
    if (owner[s] >= 0) begin
      foreach (flight[j]) begin
        if (flight[j].seq == owner[s]) begin
          if (flight[j].done) v = flight[j].res;
          else begin rdy = 1'b0; t = owner[s]; end
        end
      end
    end
  endtask

  task automatic step(bit dv, int op, int a, int b, int d, bit busy, bit exc, string ctx);
    int pick;
    bit flush, do_ret, take;
    int res;
    inst_t e;
    @(negedge clk);
    disp_valid = dv; disp_op = OP_W'(op); disp_src1 = 3'(a); disp_src2 = 3'(b);
    disp_dst = 3'(d); alu_busy = busy; exc_in = exc;
    #1;
    flush = exc && flight.size() > 0;
    chk({ctx, " R2"}, "disp_ready", int'(disp_ready), int'(flight.size() < DEPTH));
    pick = -1;
    if (!flush && !busy) begin
      for (int k = flight.size() - 1; k >= 0; k--)
        if (flight[k].r1 && flight[k].r2 && !flight[k].done) pick = k;
    end
    chk({ctx, " R4"}, "exe_valid", int'(exe_valid), int'(pick >= 0));
    res = 0;
    if (pick >= 0) begin
      chk({ctx, " R4"}, "exe_tag", int'(exe_tag), flight[pick].seq % DEPTH);
      chk({ctx, " R4"}, "exe_op", int'(exe_op), flight[pick].op);
      chk({ctx, " R3/R5/R6/R10/R11"}, "exe_a", int'(exe_a), flight[pick].v1);
      chk({ctx, " R3/R5/R6/R10/R11"}, "exe_b", int'(exe_b), flight[pick].v2);
      res = alu(flight[pick].op, flight[pick].v1, flight[pick].v2);
    end
    do_ret = !flush && flight.size() > 0 && flight[0].done;
    chk({ctx, " R7"}, "ret_valid", int'(ret_valid), int'(do_ret));
    if (do_ret) begin
      chk({ctx, " R7/R8"}, "ret_reg", int'(ret_reg), flight[0].dst);
      chk({ctx, " R7/R8"}, "ret_data", int'(ret_data), flight[0].res);
    end
    exe_result = DATA_W'(alu(int'(exe_op), int'(exe_a), int'(exe_b)));
    // model update for the coming edge
    if (flush) begin
      flight.delete();
      foreach (owner[r]) owner[r] = -1;
      tail_seq = head_seq;
    end else begin
      if (pick >= 0) begin
        flight[pick].done = 1'b1;
        flight[pick].res = res;
        foreach (flight[j]) begin
          if (!flight[j].r1 && flight[j].t1 == flight[pick].seq) begin flight[j].r1 = 1'b1; flight[j].v1 = res; end
          if (!flight[j].r2 && flight[j].t2 == flight[pick].seq) begin flight[j].r2 = 1'b1; flight[j].v2 = res; end
        end
      end
      take = dv && flight.size() < DEPTH;
      if (take) begin
        e.op = op; e.dst = d; e.done = 1'b0; e.res = 0;
        source(a, e.r1, e.v1, e.t1);
        source(b, e.r2, e.v2, e.t2);
      end
      if (do_ret) begin
        regval[flight[0].dst] = flight[0].res;
        if (owner[flight[0].dst] == flight[0].seq) owner[flight[0].dst] = -1;
        void'(flight.pop_front());
        head_seq++;
      end
      if (take) begin
        e.seq = tail_seq;
        tail_seq++;
        owner[d] = e.seq;
        flight.push_back(e);
      end
    end
  endtask

  task automatic drain(string ctx);
    for (int n = 0; n < 8; n++) step(0, 0, 0, 0, 0, 0, 0, ctx);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    foreach (owner[r]) begin owner[r] = -1; regval[r] = 0; end
    head_seq = 0; tail_seq = 0; checks = 0; errors = 0; finished = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "disp_ready after reset", int'(disp_ready), 1);
    chk("R1", "exe_valid after reset", int'(exe_valid), 0);
    chk("R1", "ret_valid after reset", int'(ret_valid), 0);

    // R1/R3: unmapped sources read committed zeros
    step(1, 3, 0, 0, 1, 0, 0, "R1/R3 unmapped");
    step(1, 4, 5, 6, 2, 0, 0, "R1/R3 unmapped");
    drain("R3 drain");

    // R5/R6: back-to-back dependency chain
    step(1, 3, 1, 1, 3, 0, 0, "R6 chain");
    step(1, 0, 3, 3, 4, 0, 0, "R6 chain");
    step(1, 1, 4, 3, 5, 0, 0, "R6 chain");
    step(1, 2, 5, 4, 6, 0, 0, "R5 chain");
    drain("R5 drain");

    // R5: wakeup after stalled producer
    step(1, 3, 2, 2, 7, 1, 0, "R5 held");
    step(1, 0, 7, 2, 1, 1, 0, "R5 held");
    step(0, 0, 0, 0, 0, 1, 0, "R5 held");
    drain("R5 release");

    // R8: younger mapping survives retirement of older one
    step(1, 3, 1, 1, 2, 0, 0, "R8");
    step(1, 5, 2, 2, 2, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, "R8");
    step(1, 0, 2, 1, 3, 1, 0, "R8");
    drain("R8 drain");

    // R2: fill while the ALU is held, then offer more
    for (int n = 0; n < 7; n++) step(1, n % 8, n % 8, (n + 3) % 8, n % 8, 1, 0, "R2 full");
    drain("R2 drain");

    // R9: flush with dispatch offered, then reuse flushed registers
    step(1, 3, 1, 1, 1, 1, 0, "R9 fill");
    step(1, 4, 1, 2, 2, 1, 0, "R9 fill");
    step(1, 0, 2, 2, 5, 1, 1, "R9 flush");
    step(1, 0, 1, 2, 3, 0, 0, "R9 after");
    step(0, 0, 0, 0, 0, 0, 1, "R9 empty exc");
    drain("R9 drain");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++)
      step(($urandom % 10) < 7, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8,
           ($urandom % 10) < 3, ($urandom % 50) == 0, "R4/R9 random");
    drain("final drain");
    finish_run();
  end

endmodule